// File: doc/BRIEF.md
# MAC Table Ageing Engine

This block is the background ageing engine that sits beside a MAC address table. It keeps, for each table slot, a valid bit, a locked bit and a one-bit activity flag. A programmable timebase produces base units of 1 µs, 100 µs, 10 ms or 1 s from the system clock. A period counter counts those units and starts an ageing sweep when it reaches the programmed period. The sweep walks every slot in index order, one slot per clock. A valid, unlocked slot whose activity flag is clear is dropped. Every other slot has its activity flag cleared.

Ageing works on a single activity bit. An idle slot therefore disappears on the second sweep after its last activity. Software that wants a target age time T milliseconds takes T/10 (at least 1) in 10 ms units and programs half of that as the period. Slots are installed through a learn port, which marks them active. Forwarding hits raise a slot's activity flag through a hit port. A flush input empties the whole table before ageing is enabled.

Top module: `mac_age_engine`

## Requirements
- R1: After reset, and one cycle after `flush` is asserted, every slot reads invalid, unlocked and inactive.
- R2: A learn pulse for slot i makes slot i valid and active on the next cycle, with its locked bit taken from `learn_lock`.
- R3: A period value of 0 disables ageing: no slot is ever dropped or has its activity flag cleared, and the timebase counters are held at zero.
- R4: With the period changed from 0 to P, the first sweep visits slot k at clock edge P·U·C + k, counted from the first edge with P nonzero (edge 0). U is the unit length in µs: code 0 = 1, code 1 = 100, code 2 = 10000, code 3 = 1000000. C is the clocks-per-µs parameter. Later sweeps follow every P·U·C edges.
- R5: A sweep clears the activity flag of every slot it keeps. A valid, unlocked slot with a clear flag is dropped, so an idle slot survives one sweep and is dropped by the next.
- R6: A valid slot with the locked bit set is never dropped by a sweep.
- R7: A hit on a valid slot sets its activity flag on the next cycle. A hit on an invalid slot leaves it invalid and inactive.
- R8: A hit on the slot the sweep is visiting in that same cycle wins: the slot is kept and its activity flag reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_unit | input | 2 | Base unit code (0: 1 µs, 1: 100 µs, 2: 10 ms, 3: 1 s) |
| cfg_period | input | PERIOD_W | Sweep period in base units; 0 disables ageing |
| flush | input | 1 | Empty the whole table |
| learn_vld | input | 1 | Install a slot |
| learn_idx | input | $clog2(N_ENT) | Slot to install |
| learn_lock | input | 1 | Locked bit of the installed slot |
| hit_vld | input | 1 | Activity hit |
| hit_idx | input | $clog2(N_ENT) | Slot that saw activity |
| ent_valid | output | N_ENT | Valid bit per slot |
| ent_locked | output | N_ENT | Locked bit per slot |
| ent_active | output | N_ENT | Activity flag per slot |

## Verification
The hardest case to reach is a hit that lands in the exact cycle the sweep visits that slot, with the slot already idle, so that only the hit keeps it alive. The bench brings the timebase up from a period of 0 at a known edge. From the R4 formula it computes the edge at which the second sweep reaches the slot, and drives the hit for that one cycle only. A neighbouring idle slot without a hit is checked to disappear a few edges later in the same sweep.

// File: rtl/mac_age_pkg.sv
package mac_age_pkg;

    localparam int UNIT_W = 20;

    typedef enum logic [1:0] {
        UNIT_1US   = 2'd0,
        UNIT_100US = 2'd1,
        UNIT_10MS  = 2'd2,
        UNIT_1S    = 2'd3
    } unit_e;

    typedef struct packed {
        logic vld;
        logic lck;
        logic act;
    } slot_t;

    function automatic logic [UNIT_W-1:0] unit_len_us(input unit_e u);
        case (u)
            UNIT_1US:   return UNIT_W'(1);
            UNIT_100US: return UNIT_W'(100);
            UNIT_10MS:  return UNIT_W'(10000);
            default:    return UNIT_W'(1000000);
        endcase
    endfunction

endpackage

// File: rtl/mac_age_timebase.sv
module mac_age_timebase
    import mac_age_pkg::*;
#(
    parameter int CLK_PER_US = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] unit_code,
    output logic       unit_tick
);
    localparam int DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

    logic [DW-1:0]     div_q;
    logic [UNIT_W-1:0] ucnt_q;
    logic [UNIT_W-1:0] ulen;
    logic              us_tick;

    assign ulen      = unit_len_us(unit_e'(unit_code));
    assign us_tick   = en && (div_q == DW'(CLK_PER_US - 1));
    assign unit_tick = us_tick && (ucnt_q >= ulen - UNIT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            div_q  <= '0;
            ucnt_q <= '0;
        end else begin
            div_q <= us_tick ? '0 : div_q + DW'(1);
            if (unit_tick)
                ucnt_q <= '0;
            else if (us_tick)
                ucnt_q <= ucnt_q + UNIT_W'(1);
        end
    end

    AST_IDLE_HELD: assert property (@(posedge clk) disable iff (rst)
        !en |=> (div_q == '0 && ucnt_q == '0)); // R3

endmodule

// File: rtl/mac_age_sweeper.sv
module mac_age_sweeper #(
    parameter int N_ENT    = 16,
    parameter int PERIOD_W = 16,
    localparam int IW      = $clog2(N_ENT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PERIOD_W-1:0] period,
    input  logic                unit_tick,
    output logic                visit_vld,
    output logic [IW-1:0]       visit_idx
);
    logic [PERIOD_W-1:0] pcnt_q;
    logic                en;
    logic                go;
    logic                busy_q;
    logic [IW-1:0]       idx_q;

    assign en = (period != '0);
    assign go = en && unit_tick && (pcnt_q == period - PERIOD_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !en)
            pcnt_q <= '0;
        else if (go)
            pcnt_q <= '0;
        else if (unit_tick)
            pcnt_q <= pcnt_q + PERIOD_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (busy_q) begin
            if (idx_q == IW'(N_ENT - 1))
                busy_q <= 1'b0;
            idx_q <= idx_q + IW'(1);
        end else if (go) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
        end
    end

    assign visit_vld = busy_q;
    assign visit_idx = idx_q;

    AST_WALK_ORDER: assert property (@(posedge clk) disable iff (rst)
        (busy_q && idx_q != IW'(N_ENT - 1)) |=> (busy_q && idx_q == $past(idx_q) + IW'(1))); // R4
    AST_NO_START_OFF: assert property (@(posedge clk) disable iff (rst)
        (!en && !busy_q) |=> !busy_q); // R3

endmodule

// File: rtl/mac_age_table.sv
module mac_age_table
    import mac_age_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IW   = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             learn_vld,
    input  logic [IW-1:0]    learn_idx,
    input  logic             learn_lock,
    input  logic             hit_vld,
    input  logic [IW-1:0]    hit_idx,
    input  logic             visit_vld,
    input  logic [IW-1:0]    visit_idx,
    output logic [N_ENT-1:0] vld,
    output logic [N_ENT-1:0] lck,
    output logic [N_ENT-1:0] act
);
    slot_t slot_q [N_ENT];
    slot_t slot_d [N_ENT];

    always_comb begin
        for (int k = 0; k < N_ENT; k++) begin
            logic hit_k, ins_k, vis_k;
            hit_k = hit_vld && (hit_idx == IW'(k));
            ins_k = learn_vld && (learn_idx == IW'(k));
            vis_k = visit_vld && (visit_idx == IW'(k));
            slot_d[k] = slot_q[k];
            if (flush) begin
                slot_d[k] = '0;
            end else if (ins_k) begin
                slot_d[k] = '{vld: 1'b1, lck: learn_lock, act: 1'b1};
            end else if (slot_q[k].vld) begin
                if (vis_k) begin
                    if (!slot_q[k].lck && !slot_q[k].act && !hit_k)
                        slot_d[k] = '0;
                    else
                        slot_d[k].act = hit_k;
                end else if (hit_k) begin
                    slot_d[k].act = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < N_ENT; k++)
            slot_q[k] <= rst ? '0 : slot_d[k];
    end

    always_comb begin
        for (int k = 0; k < N_ENT; k++) begin
            vld[k] = slot_q[k].vld;
            lck[k] = slot_q[k].lck;
            act[k] = slot_q[k].act;
        end
    end

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (vld == '0 && act == '0)); // R1
    AST_LEARN_SETS: assert property (@(posedge clk) disable iff (rst)
        (learn_vld && !flush) |=> (vld[$past(learn_idx)] && act[$past(learn_idx)])); // R2
    AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (rst)
        !flush |=> ((($past(vld & lck)) & ~vld) == '0)); // R6
    AST_HIT_WINS: assert property (@(posedge clk) disable iff (rst)
        (hit_vld && vld[hit_idx] && !flush) |=> act[$past(hit_idx)]); // R7 R8

endmodule

// File: rtl/mac_age_engine.sv
module mac_age_engine #(
    parameter int N_ENT      = 16,
    parameter int CLK_PER_US = 200,
    parameter int PERIOD_W   = 16,
    localparam int IW        = $clog2(N_ENT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          cfg_unit,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic                flush,
    input  logic                learn_vld,
    input  logic [IW-1:0]       learn_idx,
    input  logic                learn_lock,
    input  logic                hit_vld,
    input  logic [IW-1:0]       hit_idx,
    output logic [N_ENT-1:0]    ent_valid,
    output logic [N_ENT-1:0]    ent_locked,
    output logic [N_ENT-1:0]    ent_active
);
    logic          unit_tick;
    logic          visit_vld;
    logic [IW-1:0] visit_idx;

    mac_age_timebase #(.CLK_PER_US(CLK_PER_US)) u_tb (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg_period != '0),
        .unit_code (cfg_unit),
        .unit_tick (unit_tick)
    );

    mac_age_sweeper #(.N_ENT(N_ENT), .PERIOD_W(PERIOD_W)) u_sw (
        .clk       (clk),
        .rst       (rst),
        .period    (cfg_period),
        .unit_tick (unit_tick),
        .visit_vld (visit_vld),
        .visit_idx (visit_idx)
    );

    mac_age_table #(.N_ENT(N_ENT)) u_tab (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .learn_vld  (learn_vld),
        .learn_idx  (learn_idx),
        .learn_lock (learn_lock),
        .hit_vld    (hit_vld),
        .hit_idx    (hit_idx),
        .visit_vld  (visit_vld),
        .visit_idx  (visit_idx),
        .vld        (ent_valid),
        .lck        (ent_locked),
        .act        (ent_active)
    );

endmodule

// File: tb/tb_mac_age_engine.sv
`timescale 1ns/1ps
module tb_mac_age_engine;
    localparam int N  = 8;
    localparam int C  = 2;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cfg_unit = 2'd0;
    logic [PW-1:0] cfg_period = '0;
    logic          flush = 1'b0;
    logic          learn_vld = 1'b0;
    logic [2:0]    learn_idx = '0;
    logic          learn_lock = 1'b0;
    logic          hit_vld = 1'b0;
    logic [2:0]    hit_idx = '0;
    logic [N-1:0]  ent_valid, ent_locked, ent_active;

    always #2.5 clk = ~clk;

    mac_age_engine #(.N_ENT(N), .CLK_PER_US(C), .PERIOD_W(PW)) dut (
        .clk(clk), .rst(rst), .cfg_unit(cfg_unit), .cfg_period(cfg_period),
        .flush(flush), .learn_vld(learn_vld), .learn_idx(learn_idx),
        .learn_lock(learn_lock), .hit_vld(hit_vld), .hit_idx(hit_idx),
        .ent_valid(ent_valid), .ent_locked(ent_locked), .ent_active(ent_active)
    );

    typedef struct {
        string        tag;
        logic [N-1:0] mask;
        logic [N-1:0] ev;
        logic [N-1:0] ea;
    } item_t;

    item_t sbq [$];
    int n_cmp = 0;
    int n_bad = 0;
    int now   = 0;

    // monitor: compares pending expectations shortly after each falling edge
    always @(negedge clk) begin
        #1;
        while (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            n_cmp++;
            if (((ent_valid & it.mask) != it.ev) || ((ent_active & it.mask) != it.ea)) begin
                n_bad++;
                $display("FAIL %s: valid=%b active=%b expected valid=%b active=%b (mask %b)",
                         it.tag, ent_valid & it.mask, ent_active & it.mask, it.ev, it.ea, it.mask);
            end
        end
    end

    task automatic expect_state(string tag, logic [N-1:0] mask, logic [N-1:0] ev, logic [N-1:0] ea);
        item_t it;
        it.tag = tag; it.mask = mask; it.ev = ev & mask; it.ea = ea & mask;
        sbq.push_back(it);
    endtask

    task automatic step(int n);
        repeat (n) begin
            @(negedge clk);
            now++;
        end
    endtask

    // edge e counted from the first edge with a nonzero period
    task automatic goto_edge(int e);
        step(e - now);
    endtask

    task automatic arm(logic [1:0] u, logic [PW-1:0] p);
        cfg_period = '0;
        step(1);
        cfg_unit   = u;
        cfg_period = p;
        now = -1;
    endtask

    task automatic learn(int idx, logic lock_b);
        learn_vld = 1'b1; learn_idx = 3'(idx); learn_lock = lock_b;
        step(1);
        learn_vld = 1'b0;
    endtask

    task automatic hit(int idx);
        hit_vld = 1'b1; hit_idx = 3'(idx);
        step(1);
        hit_vld = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        expect_state("R1 reset empty", '1, 8'h00, 8'h00);
        step(1);

        learn(0, 1'b0);
        learn(1, 1'b1);
        learn(2, 1'b0);
        expect_state("R2 learn valid+active", '1, 8'h07, 8'h07);
        if (ent_locked != 8'h02) begin
            n_bad++;
            $display("FAIL R2 locked: actual=%b expected=%b", ent_locked, 8'h02);
        end
        n_cmp++;

        // period 0: nothing ages; hit on invalid slot ignored
        hit(6);
        expect_state("R7 hit invalid ignored", '1, 8'h07, 8'h07);
        step(300);
        expect_state("R3 period 0 no ageing", '1, 8'h07, 8'h07);
        step(1);

        // unit code 1: 100 us * 2 clk = 200 clk/unit, period 2 -> 400 edges
        arm(2'd1, 8'd2);
        goto_edge(399);
        expect_state("R4 before first sweep", '1, 8'h07, 8'h07);
        goto_edge(408);
        expect_state("R5 first sweep clears flags", '1, 8'h07, 8'h00);
        goto_edge(458);
        hit(2);
        expect_state("R7 hit sets flag", '1, 8'h07, 8'h04);
        goto_edge(799);
        expect_state("R4 before second sweep", '1, 8'h07, 8'h04);
        goto_edge(808);
        expect_state("R5 idle dropped, active kept", '1, 8'h06, 8'h00);
        goto_edge(1208);
        expect_state("R6 locked survives third sweep", '1, 8'h02, 8'h00);
        step(1);

        cfg_period = '0;
        flush = 1'b1;
        step(1);
        flush = 1'b0;
        expect_state("R1 flush empties", '1, 8'h00, 8'h00);
        step(1);

        // unit code 2: 10 ms * 2 clk = 20000 clk/unit, period 1
        learn(4, 1'b0);
        arm(2'd2, 8'd1);
        goto_edge(19999);
        expect_state("R4 code2 before sweep", 8'h10, 8'h10, 8'h10);
        goto_edge(20008);
        expect_state("R4 code2 first sweep", 8'h10, 8'h10, 8'h00);
        goto_edge(39999);
        expect_state("R5 code2 kept until second", 8'h10, 8'h10, 8'h00);
        goto_edge(40008);
        expect_state("R5 code2 dropped", 8'h10, 8'h00, 8'h00);
        step(1);

        // unit code 0, period 20 -> sweeps visit slot k at edges 40+k, 80+k
        cfg_period = '0;
        learn(3, 1'b0);
        learn(5, 1'b0);
        arm(2'd0, 8'd20);
        goto_edge(48);
        expect_state("R5 code0 first sweep", '1, 8'h28, 8'h00);
        goto_edge(82);
        hit(3);
        expect_state("R8 hit wins over sweep", 8'h08, 8'h08, 8'h08);
        goto_edge(88);
        expect_state("R8 neighbour dropped", '1, 8'h08, 8'h08);
        step(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule